// File: doc/BRIEF.md
# Subcycle-Sequenced Accumulator Processor

A 16-bit accumulator machine. Each instruction runs as a fixed series of numbered subcycles, and each subcycle enables exactly one register transfer. The machine holds an internal word memory, an address register, an instruction register, a memory buffer register (MBR), the accumulator G and an arithmetic unit. The arithmetic unit has input registers X and Y, a result register Z and a debug copy of Z.

Addition is not done as a single accumulate step. It is spread over five transfers: memory to MBR, MBR to X, G to Y, X+Y to Z, and Z to G.

A test harness fills the memory through a preload port while reset is held. It then releases reset, waits for the halted output and reads the memory back through the same port.

Top module: `acc_seq_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the subcycle counter and every register (G, MBR, X, Y, Z and the debug copy). While in reset, `halted` is 0 and `z_dbg` is 0. After reset, execution starts at address 0 with G equal to 0.
- R2: An instruction word carries its opcode in bits 15:12 and a 12-bit operand address in bits 11:0. Opcode 0x0 is halt, 0x1 adds the memory word to G, 0x6 loads G from memory and 0x7 stores G to memory. Every other opcode (including the word 0xFFFF) is a no-op. At most one transfer is enabled per subcycle.
- R3: Load copies the memory word at the operand address into G through the MBR. Store writes G to the operand address through the MBR.
- R4: Add leaves G equal to (G + memory word) modulo 2^16, with no carry kept. The transfers follow the order memory→MBR (subcycle 3), MBR→X (4), G→Y (5), X+Y→Z (6), Z→G (7).
- R5: `z_dbg` copies Z one clock after Z changes and keeps it otherwise.
- R6: Fetch takes subcycles 0–2. No-ops take 3 clocks, load and store take 5, and add takes 8. After the last subcycle, the counter returns to 0.
- R7: Halt raises `halted` in its third subcycle. After that, no instruction runs, no memory word changes and `z_dbg` stays stable until reset.
- R8: The preload port writes memory only while reset is held. A `pre_we` pulse while running has no effect.
- R9: The eight-word program nop, load 0x100, store 0x200, load 0x101, store 0x201, add 0x200, store 0x202, halt, with 0xABCD at 0x100 and 0x1234 at 0x101, leaves 0xABCD, 0x1234 and 0xBE01 at 0x200..0x202.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe, honoured only in reset |
| pre_addr | input | 12 | Preload write / readback address |
| pre_wdata | input | 16 | Preload write data |
| pre_rdata | output | 16 | Memory word at `pre_addr` (combinational) |
| halted | output | 1 | High once a halt instruction has executed |
| z_dbg | output | 16 | Debug copy of result register Z |

## Verification
The first program is the reference sequence. It mixes a no-op, loads, stores and one add whose operands set no high carry. The second program chains two adds, one of which crosses 0xFFFF, so a design that keeps a carry or skips the wrap gives a different stored word. The third program runs right after the second without refilling G. It stores first, places undefined opcodes between real instructions and pulses the preload strobe during the run, which separates a correct reset, correct no-op decoding and correct preload gating from their faults. For each program, the clock count to halt is compared with the per-instruction subcycle totals, and the memory is compared again after idling in halt.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 16;
  localparam int OPC_W  = 4;
  localparam int OPD_W  = DATA_W - OPC_W;
  localparam int SC_W   = 3;

  localparam logic [OPC_W-1:0] OPC_HLT = 4'h0;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LDG = 4'h6;
  localparam logic [OPC_W-1:0] OPC_STG = 4'h7;

  typedef struct packed {
    logic mar_pc;
    logic ir_mem;
    logic pc_inc;
    logic mbr_mem;
    logic mbr_g;
    logic mem_wr;
    logic g_mbr;
    logic x_mbr;
    logic y_g;
    logic z_sum;
    logic g_z;
  } step_t;

  function automatic logic [OPC_W-1:0] opc_of(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: OPC_W];
  endfunction

  function automatic logic [OPD_W-1:0] opd_of(input logic [DATA_W-1:0] w);
    return w[OPD_W-1:0];
  endfunction

  function automatic logic uses_operand(input logic [OPC_W-1:0] o);
    return (o == OPC_ADD) || (o == OPC_LDG) || (o == OPC_STG);
  endfunction

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/word_ram.sv
module word_ram #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  output logic [SC_W-1:0]  sc,
  output logic             halted,
  output step_t            step
);
  logic last_step;
  logic halt_now;

  always_comb begin
    step      = '0;
    last_step = 1'b0;
    halt_now  = 1'b0;
    if (!halted) begin
      case (sc)
        3'd0: step.mar_pc = 1'b1;
        3'd1: step.ir_mem = 1'b1;
        3'd2: begin
          step.pc_inc = 1'b1;
          if (opc == OPC_HLT) halt_now = 1'b1;
          else if (!uses_operand(opc)) last_step = 1'b1;
        end
        3'd3: begin
          if (opc == OPC_STG) step.mbr_g = 1'b1;
          else step.mbr_mem = 1'b1;
        end
        3'd4: begin
          if (opc == OPC_LDG) begin
            step.g_mbr = 1'b1;
            last_step  = 1'b1;
          end else if (opc == OPC_STG) begin
            step.mem_wr = 1'b1;
            last_step   = 1'b1;
          end else begin
            step.x_mbr = 1'b1;
          end
        end
        3'd5: step.y_g = 1'b1;
        3'd6: step.z_sum = 1'b1;
        default: begin
          step.g_z  = 1'b1;
          last_step = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc     <= '0;
      halted <= 1'b0;
    end else if (halt_now) begin
      halted <= 1'b1;
    end else if (last_step) begin
      sc <= '0;
    end else if (!halted) begin
      sc <= sc + 1'b1;
    end
  end

  // R2: one transfer per subcycle
  a_r2_one_transfer: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step));
  // R6: the add's last subcycle returns the counter to zero
  a_r6_wrap_after_last: assert property (@(posedge clk) disable iff (rst)
    (sc == 3'd7) |=> (sc == 3'd0));
  // R6: short instructions end after fetch
  a_r6_short_ends: assert property (@(posedge clk) disable iff (rst)
    (sc == 3'd2 && !halted && opc != OPC_HLT && !uses_operand(opc)) |=> (sc == 3'd0));
  // R7: halt holds until reset
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R7: no subcycle advance while halted
  a_r7_halt_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(sc));
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import acc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_ld,
  input  logic          y_ld,
  input  logic          z_ld,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [DW-1:0] z_q,
  output logic [DW-1:0] zb_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      y_q  <= '0;
      z_q  <= '0;
      zb_q <= '0;
    end else begin
      if (x_ld) x_q <= x_in;
      if (y_ld) y_q <= y_in;
      if (z_ld) z_q <= add_wrap(x_q, y_q);
      zb_q <= z_q;
    end
  end

  // R4: Z changes only on its load step
  a_r4_z_holds: assert property (@(posedge clk) disable iff (rst)
    !z_ld |=> $stable(z_q));
  // R5: debug copy agrees with Z one clock after a load
  a_r5_zb_catches_up: assert property (@(posedge clk) disable iff (rst)
    z_ld |=> ##1 (zb_q == z_q));
endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [OPD_W-1:0]  pre_addr,
  input  logic [DATA_W-1:0] pre_wdata,
  output logic [DATA_W-1:0] pre_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] z_dbg
);
  logic [OPD_W-1:0]  pc_q;
  logic [OPD_W-1:0]  mar_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] g_q;
  logic [DATA_W-1:0] mbr_q;
  logic [SC_W-1:0]   sc;
  step_t             step;

  logic [DATA_W-1:0] x_q, y_q, z_q;
  logic [OPD_W-1:0]  cpu_raddr;
  logic [DATA_W-1:0] cpu_rdata;
  logic              ram_we;
  logic [OPD_W-1:0]  ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opc    (opc_of(ir_q)),
    .sc     (sc),
    .halted (halted),
    .step   (step)
  );

  assign cpu_raddr = step.ir_mem ? mar_q : opd_of(ir_q);
  assign ram_we    = rst ? pre_we    : step.mem_wr;
  assign ram_waddr = rst ? pre_addr  : opd_of(ir_q);
  assign ram_wdata = rst ? pre_wdata : mbr_q;

  word_ram #(.DW(DATA_W), .AW(OPD_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr_a (cpu_raddr),
    .rdata_a (cpu_rdata),
    .raddr_b (pre_addr),
    .rdata_b (pre_rdata)
  );

  alu_unit #(.DW(DATA_W)) u_alu (
    .clk  (clk),
    .rst  (rst),
    .x_ld (step.x_mbr),
    .y_ld (step.y_g),
    .z_ld (step.z_sum),
    .x_in (mbr_q),
    .y_in (g_q),
    .x_q  (x_q),
    .y_q  (y_q),
    .z_q  (z_q),
    .zb_q (z_dbg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      g_q   <= '0;
      mbr_q <= '0;
    end else begin
      if (step.mar_pc)  mar_q <= pc_q;
      if (step.ir_mem)  ir_q  <= cpu_rdata;
      if (step.pc_inc)  pc_q  <= pc_q + 1'b1;
      if (step.mbr_mem) mbr_q <= cpu_rdata;
      if (step.mbr_g)   mbr_q <= g_q;
      if (step.g_mbr)   g_q   <= mbr_q;
      if (step.g_z)     g_q   <= z_q;
    end
  end

  // R3: a store writes the accumulator's current value
  a_r3_store_source: assert property (@(posedge clk) disable iff (rst)
    step.mem_wr |-> (mbr_q == g_q));
  // R4: X holds the fetched operand when G moves to Y
  a_r4_x_from_mbr: assert property (@(posedge clk) disable iff (rst)
    step.y_g |-> (x_q == mbr_q));
  // R4: Y holds the accumulator when the sum is taken
  a_r4_y_from_g: assert property (@(posedge clk) disable iff (rst)
    step.z_sum |-> (y_q == g_q));
  // R7: nothing is written to memory once halted
  a_r7_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ram_we);
endmodule

// File: tb/acc_seq_cpu_bench.sv
module acc_seq_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = '0;
  logic [15:0] pre_wdata = '0;
  logic [15:0] pre_rdata;
  logic        halted;
  logic [15:0] z_dbg;

  acc_seq_cpu u_acc_seq_cpu (
    .clk       (clk),
    .rst       (rst),
    .pre_we    (pre_we),
    .pre_addr  (pre_addr),
    .pre_wdata (pre_wdata),
    .pre_rdata (pre_rdata),
    .halted    (halted),
    .z_dbg     (z_dbg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [11:0] a;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_go = 1'b0;
  bit   mon_done = 1'b0;

  function automatic logic [15:0] sum16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = 17'(a) + 17'(b);
    return t[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    pre_addr  = a;
    pre_wdata = d;
    pre_we    = 1'b1;
    @(negedge clk);
    pre_we    = 1'b0;
  endtask

  task automatic expect_word(input logic [11:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    mon_done = 1'b0;
    mon_go   = 1'b1;
    wait (mon_done);
  endtask

  task automatic run_prog(input int exp_cycles, input bit hammer, input string tag);
    int cyc;
    cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    if (hammer) begin
      pre_addr  = 12'h040;
      pre_wdata = 16'hDEAD;
      pre_we    = 1'b1;
    end
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted || cyc > 400) break;
    end
    pre_we = 1'b0;
    check(cyc == exp_cycles, tag, 16'(cyc), 16'(exp_cycles));
  endtask

  // monitor: pops expected memory words and compares them
  initial begin
    forever begin
      wait (mon_go);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        @(negedge clk);
        pre_addr = e.a;
        #1;
        check(pre_rdata === e.d, e.tag, pre_rdata, e.d);
      end
      mon_go   = 1'b0;
      mon_done = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 halted low in reset", 16'(halted), 16'h0);
    check(z_dbg == 16'h0, "R1 z_dbg clear in reset", z_dbg, 16'h0);

    // program 1: reference sequence (R9, R2 nop 0xFFFF, R3, R4)
    poke(12'h000, 16'hFFFF);
    poke(12'h001, 16'h6100);
    poke(12'h002, 16'h7200);
    poke(12'h003, 16'h6101);
    poke(12'h004, 16'h7201);
    poke(12'h005, 16'h1200);
    poke(12'h006, 16'h7202);
    poke(12'h007, 16'h0000);
    poke(12'h100, 16'hABCD);
    poke(12'h101, 16'h1234);
    poke(12'h200, 16'h0000);
    poke(12'h201, 16'h0000);
    poke(12'h202, 16'h0000);
    run_prog(3 + 5*4 + 8 + 5 + 3, 1'b0, "R6 program1 cycles to halt");
    check(halted == 1'b1, "R7 halted after program1", 16'(halted), 16'h1);
    check(z_dbg == sum16(16'hABCD, 16'h1234), "R5 z_dbg after add", z_dbg,
          sum16(16'hABCD, 16'h1234));
    expect_word(12'h200, 16'hABCD, "R9 word 0x200");
    expect_word(12'h201, 16'h1234, "R9 word 0x201");
    expect_word(12'h202, sum16(16'hABCD, 16'h1234), "R9 R4 word 0x202");
    expect_word(12'h100, 16'hABCD, "R3 load source unchanged");
    drain();

    // program 2: chained adds with wrap (R4)
    @(negedge clk);
    rst = 1'b1;
    poke(12'h000, 16'h6010);
    poke(12'h001, 16'h1011);
    poke(12'h002, 16'h1012);
    poke(12'h003, 16'h7020);
    poke(12'h004, 16'h0000);
    poke(12'h010, 16'hFFFF);
    poke(12'h011, 16'h0002);
    poke(12'h012, 16'h8000);
    poke(12'h020, 16'h0000);
    run_prog(5 + 8 + 8 + 5 + 3, 1'b0, "R6 program2 cycles to halt");
    check(z_dbg == sum16(sum16(16'hFFFF, 16'h0002), 16'h8000), "R5 R4 z_dbg wrap", z_dbg,
          sum16(sum16(16'hFFFF, 16'h0002), 16'h8000));
    expect_word(12'h020, sum16(sum16(16'hFFFF, 16'h0002), 16'h8000), "R4 wrapped sum stored");
    drain();

    // program 3: reset clears G, undefined opcodes, preload gated (R1 R2 R8)
    @(negedge clk);
    rst = 1'b1;
    poke(12'h000, 16'h7030);
    poke(12'h001, 16'h2031);
    poke(12'h002, 16'h6032);
    poke(12'h003, 16'h3033);
    poke(12'h004, 16'h7034);
    poke(12'h005, 16'h0000);
    poke(12'h030, 16'h5555);
    poke(12'h031, 16'h7777);
    poke(12'h032, 16'h0C0C);
    poke(12'h033, 16'h9999);
    poke(12'h034, 16'h0000);
    poke(12'h040, 16'h1111);
    @(negedge clk);
    check(z_dbg == 16'h0, "R1 z_dbg cleared by reset", z_dbg, 16'h0);
    run_prog(5 + 3 + 5 + 3 + 5 + 3, 1'b1, "R6 R2 program3 cycles to halt");
    expect_word(12'h030, 16'h0000, "R1 G cleared by reset");
    expect_word(12'h031, 16'h7777, "R2 undefined opcode no write");
    expect_word(12'h033, 16'h9999, "R2 undefined opcode no write 2");
    expect_word(12'h034, 16'h0C0C, "R3 load then store");
    expect_word(12'h040, 16'h1111, "R8 preload ignored while running");
    drain();

    // idle in halt (R7)
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b1, "R7 halted stays high", 16'(halted), 16'h1);
    check(z_dbg == 16'h0, "R7 z_dbg stable in halt", z_dbg, 16'h0);
    expect_word(12'h034, 16'h0C0C, "R7 memory stable in halt");
    expect_word(12'h000, 16'h7030, "R7 program intact in halt");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule